// File: doc/BRIEF.md
# Dual-Sequence Burst Beat Address Generator

This block produces the low address bits used for the beats of a short burst, with four beats at the default width. When a fresh address is captured, the block takes its starting value from the least significant bits of that address. On each later clock edge where the active-low step input is low, it moves to the next beat. When the step input is high, it holds the current beat as a wait state.

The static `seq_interleave` level selects the ordering. With the level low, each beat address is the start value plus the beat number, wrapping at the counter width. With the level high, each beat address is the start value XOR the beat number. In both orderings, once every beat has been issued, the next step returns the address to the start value.

A sticky `burst_done` flag reports that the final beat has been reached. It is cleared by the next load or by reset. Upper address bits, storage and data paths belong to neighbouring blocks.

Top module: `burst_addr_ctr`

## Requirements
- R1: A synchronous active-high `rst` sampled on a rising edge sets `addr_lo` to 0 and `burst_done` to 0 after that edge.
- R2: An edge with `ld_strobe` = 1 captures `start_lo`, and `addr_lo` equals that captured value after the edge.
- R3: With `seq_interleave` = 0 (linear), the address of beat k is (start + k) modulo 2^CNT_W.
- R4: With `seq_interleave` = 1 (interleaved), the address of beat k is start XOR k.
- R5: Each non-load edge with `adv_n` = 0 moves exactly one beat forward, and the step after the last beat returns `addr_lo` to the start value.
- R6: A non-load edge with `adv_n` = 1 leaves `addr_lo` and `burst_done` unchanged.
- R7: On an edge with `ld_strobe` = 1, the value of `adv_n` has no effect, and the burst begins at beat 0.
- R8: `seq_interleave` is not sampled by the clock: changing it changes `addr_lo` at once, without a clock edge.
- R9: `burst_done` becomes 1 on the step that reaches the last beat (beat 2^CNT_W-1). It stays 1 through wrap and wait states, and becomes 0 after the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_strobe | input | 1 | Capture a new start value, active high |
| start_lo | input | CNT_W | Low bits of the newly captured address |
| adv_n | input | 1 | Step to next beat when low; wait when high |
| seq_interleave | input | 1 | Ordering select: 0 linear, 1 XOR-interleaved (static level) |
| addr_lo | output | CNT_W | Low address bits of the current beat |
| burst_done | output | 1 | Sticky flag: final beat reached since last load |

## Verification
The clocked properties assume that `seq_interleave` usually stays constant across an edge. Each step or hold property therefore excuses any cycle in which that level changed. The stimulus changes the level only while a load is being applied, or during a deliberate wait state that tests R8. In every other cycle it holds the level steady. All inputs are driven on the falling edge, so every value is settled long before the sampling edge.

// File: rtl/burst_ctr_pkg.sv
package burst_ctr_pkg;
   // Widest beat counter the library accepts
   localparam int MAX_CNT_W = 4;

   typedef enum logic {
      SEQ_LINEAR = 1'b0,
      SEQ_XOR    = 1'b1
   } seq_mode_e;
endpackage

// File: rtl/bctr_beat.sv
module bctr_beat #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             step,
   output logic [CNT_W-1:0] beat,
   output logic             done
);
   localparam logic [CNT_W-1:0] BEAT_LAST = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] BEAT_PRE  = BEAT_LAST - CNT_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         beat <= '0;
         done <= 1'b0;
      end else if (load) begin
         beat <= '0;
         done <= 1'b0;
      end else if (step) begin
         beat <= beat + CNT_W'(1);
         if (beat == BEAT_PRE) done <= 1'b1;
      end
   end

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
      step && !load |=> beat == $past(beat) + CNT_W'(1)); // R5
   AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
      load |=> !done); // R9
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
      done && !load |=> done); // R9
endmodule

// File: rtl/bctr_map.sv
module bctr_map
   import burst_ctr_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic [CNT_W-1:0] start,
   input  logic [CNT_W-1:0] beat,
   input  logic             mode,
   output logic [CNT_W-1:0] addr
);
   logic [CNT_W-1:0] lin_addr;
   logic [CNT_W-1:0] xor_addr;

   assign lin_addr = start + beat;

   for (genvar b = 0; b < CNT_W; b++) begin : g_xor_bit
      assign xor_addr[b] = start[b] ^ beat[b];
   end

   always_comb begin
      if (seq_mode_e'(mode) == SEQ_XOR) addr = xor_addr;
      else                              addr = lin_addr;
   end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
   import burst_ctr_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_strobe,
   input  logic [CNT_W-1:0] start_lo,
   input  logic             adv_n,
   input  logic             seq_interleave,
   output logic [CNT_W-1:0] addr_lo,
   output logic             burst_done
);
   if (CNT_W < 1 || CNT_W > MAX_CNT_W) begin : g_bad_width
      $error("burst_addr_ctr: CNT_W out of range");
   end

   logic [CNT_W-1:0] start_q;
   logic [CNT_W-1:0] beat;
   logic             step;

   // A load edge overrides any advance request
   assign step = ~ld_strobe & ~adv_n;

   always_ff @(posedge clk) begin
      if (rst)            start_q <= '0;
      else if (ld_strobe) start_q <= start_lo;
   end

   bctr_beat #(.CNT_W(CNT_W)) u_beat (
      .clk  (clk),
      .rst  (rst),
      .load (ld_strobe),
      .step (step),
      .beat (beat),
      .done (burst_done)
   );

   bctr_map #(.CNT_W(CNT_W)) u_map (
      .start (start_q),
      .beat  (beat),
      .mode  (seq_interleave),
      .addr  (addr_lo)
   );

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (addr_lo == '0) && !burst_done); // R1
   AST_LOAD_START: assert property (@(posedge clk) disable iff (rst)
      ld_strobe |=> addr_lo == $past(start_lo)); // R2
   AST_LOAD_IGNORES_ADV: assert property (@(posedge clk) disable iff (rst)
      ld_strobe && !adv_n |=> addr_lo == $past(start_lo)); // R7
   AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
      step && !seq_interleave |=>
         (!$stable(seq_interleave) || addr_lo == $past(addr_lo) + CNT_W'(1))); // R3
   AST_XOR_STEP: assert property (@(posedge clk) disable iff (rst)
      step && seq_interleave |=>
         (!$stable(seq_interleave) ||
          (addr_lo ^ $past(addr_lo)) == ($past(beat) ^ ($past(beat) + CNT_W'(1))))); // R4
   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !ld_strobe && adv_n |=>
         (!$stable(seq_interleave) || ($stable(addr_lo) && $stable(burst_done)))); // R6
endmodule

// File: tb/burst_addr_ctr_test.sv
`timescale 1ns/100ps
module burst_addr_ctr_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ld_strobe = 1'b0;
   logic [1:0] start_lo = 2'd0;
   logic       adv_n = 1'b1;
   logic       seq_interleave = 1'b0;
   logic [1:0] addr_lo;
   logic       burst_done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   burst_addr_ctr #(.CNT_W(2)) uut (
      .clk            (clk),
      .rst            (rst),
      .ld_strobe      (ld_strobe),
      .start_lo       (start_lo),
      .adv_n          (adv_n),
      .seq_interleave (seq_interleave),
      .addr_lo        (addr_lo),
      .burst_done     (burst_done)
   );

   // Vector: {ld, start[1:0], adv_n, mode, exp_addr[1:0], exp_done}
   localparam int NV = 16;
   localparam logic [7:0] VEC [NV] = '{
      {1'b1, 2'd2, 1'b0, 1'b0, 2'd2, 1'b0},  // R2 R7 load 2 linear, advance ignored
      {1'b0, 2'd0, 1'b0, 1'b0, 2'd3, 1'b0},  // R3 beat1
      {1'b0, 2'd0, 1'b1, 1'b0, 2'd3, 1'b0},  // R6 wait
      {1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0},  // R3 beat2
      {1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 1'b1},  // R9 beat3
      {1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 1'b1},  // R5 wrap to start, done sticky
      {1'b1, 2'd1, 1'b0, 1'b1, 2'd1, 1'b0},  // R2 R9 load 1 interleaved
      {1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0},  // R4 1^1
      {1'b0, 2'd0, 1'b0, 1'b1, 2'd3, 1'b0},  // R4 1^2
      {1'b0, 2'd0, 1'b1, 1'b1, 2'd3, 1'b0},  // R6 wait
      {1'b0, 2'd0, 1'b0, 1'b1, 2'd2, 1'b1},  // R4 R9 1^3
      {1'b1, 2'd3, 1'b1, 1'b1, 2'd3, 1'b0},  // R2 load 3 interleaved
      {1'b0, 2'd0, 1'b0, 1'b1, 2'd2, 1'b0},  // R4 3^1
      {1'b0, 2'd0, 1'b0, 1'b1, 2'd1, 1'b0},  // R4 3^2
      {1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b1},  // R4 3^3
      {1'b0, 2'd0, 1'b0, 1'b1, 2'd3, 1'b1}   // R5 wrap to start
   };

   task automatic check(input string req, input logic [1:0] act_a, input logic [1:0] exp_a,
                        input logic act_d, input logic exp_d);
      checks++;
      if (act_a !== exp_a || act_d !== exp_d) begin
         errors++;
         $display("FAIL %s: addr_lo=%0d done=%0b expected addr_lo=%0d done=%0b",
                  req, act_a, act_d, exp_a, exp_d);
      end
   endtask

   task automatic cycle(input logic ld, input logic [1:0] st, input logic an, input logic md);
      @(negedge clk);
      ld_strobe = ld; start_lo = st; adv_n = an; seq_interleave = md;
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      check("R1 reset state", addr_lo, 2'd0, burst_done, 1'b0);

      for (int i = 0; i < NV; i++) begin
         cycle(VEC[i][7], VEC[i][6:5], VEC[i][4], VEC[i][3]);
         check($sformatf("R2-R9 vector %0d", i), addr_lo, VEC[i][2:1], burst_done, VEC[i][0]);
      end

      // R1: reset in the middle of a finished burst
      @(negedge clk); rst = 1'b1; adv_n = 1'b0;
      @(posedge clk); #1;
      check("R1 mid-burst reset", addr_lo, 2'd0, burst_done, 1'b0);
      @(negedge clk); rst = 1'b0; adv_n = 1'b1;

      // R7 R3 R5: linear from 3 with advance low on load edge, full wrap
      cycle(1'b1, 2'd3, 1'b0, 1'b0);
      check("R7 load ignores advance", addr_lo, 2'd3, burst_done, 1'b0);
      cycle(1'b0, 2'd0, 1'b0, 1'b0);
      check("R3 linear 3+1 wraps", addr_lo, 2'd0, burst_done, 1'b0);
      cycle(1'b0, 2'd0, 1'b0, 1'b0);
      check("R3 linear 3+2", addr_lo, 2'd1, burst_done, 1'b0);
      cycle(1'b0, 2'd0, 1'b0, 1'b0);
      check("R9 linear last beat", addr_lo, 2'd2, burst_done, 1'b1);
      cycle(1'b0, 2'd0, 1'b0, 1'b0);
      check("R5 return to start", addr_lo, 2'd3, burst_done, 1'b1);

      // R8: mode level acts without a clock edge (start 1, beat 1)
      cycle(1'b1, 2'd1, 1'b1, 1'b1);
      cycle(1'b0, 2'd0, 1'b0, 1'b1);
      check("R4 interleaved 1^1", addr_lo, 2'd0, burst_done, 1'b0);
      @(negedge clk); adv_n = 1'b1; seq_interleave = 1'b0;
      #1;
      check("R8 switch to linear, no edge", addr_lo, 2'd2, burst_done, 1'b0);
      seq_interleave = 1'b1;
      #1;
      check("R8 switch back to interleaved", addr_lo, 2'd0, burst_done, 1'b0);
      @(posedge clk); #1;
      check("R6 wait after mode change", addr_lo, 2'd0, burst_done, 1'b0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule